// File: doc/BRIEF.md
# Exclusive Access Rule Monitor

A passive observer on the two address channels of an AXI4 interface. It looks only at exclusive transactions, those whose lock bit is set, and reports protocol violations as one-cycle error pulses, one output per rule. It drives nothing back onto the bus and never stalls it.

When an exclusive read completes its address handshake, the monitor checks four things: the cache attributes, the byte count, whether that count is a power of two, and the beat count. It also stores the read's address, burst type and cache attributes in a per-ID record. When an exclusive write completes its address handshake, the monitor checks the write's cache attributes. It then compares the write against the stored record for the same ID, or reports that no such record exists. Records stay valid after a write, so a retried write is checked against the same read. A later exclusive read with that ID replaces the record.

Top module: `excl_access_monitor`

## Requirements
- R1: An exclusive read handshake (ar_valid, ar_ready and ar_lock all high) whose ar_cache bit 1 (modifiable) is set raises err_rd_modifiable.
- R2: An exclusive write handshake (aw_valid, aw_ready and aw_lock all high) whose aw_cache bit 1 is set raises err_wr_modifiable.
- R3: An exclusive read whose total bytes, (ar_len+1) shifted left by ar_size, exceed 128 raises err_rd_bytes_over. Exactly 128 is legal.
- R4: An exclusive read whose total byte count is not a power of two raises err_rd_bytes_not_pow2.
- R5: An exclusive read with more than 16 beats (ar_len+1 > 16) raises err_rd_len_over. Exactly 16 beats is legal.
- R6: Each exclusive read handshake stores a record for its ar_id. An exclusive write whose aw_id has no stored record raises err_wr_no_read, and all three mismatch outputs stay low for that write.
- R7: An exclusive write whose aw_addr differs from the recorded read's address raises err_wr_addr_mismatch.
- R8: An exclusive write whose aw_burst differs from the recorded read's burst type raises err_wr_burst_mismatch.
- R9: An exclusive write whose aw_cache differs from the recorded read's cache value raises err_wr_cache_mismatch.
- R10: Non-exclusive handshakes, and cycles with valid but no ready, raise no error and neither create nor change any record.
- R11: A record stays valid after exclusive writes and is replaced only by the next exclusive read with that ID. A write in the same cycle as a read with the same ID is checked against the older record.
- R12: Reset forces every error output low and discards every stored record.
- R13: Each error is a single pulse, high in exactly the cycle after the handshake edge that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read start address |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | Log2 of bytes per beat |
| ar_burst | input | 2 | Read burst type |
| ar_lock | input | 1 | Read exclusive flag |
| ar_cache | input | 4 | Read cache attributes |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write start address |
| aw_burst | input | 2 | Write burst type |
| aw_lock | input | 1 | Write exclusive flag |
| aw_cache | input | 4 | Write cache attributes |
| err_rd_modifiable | output | 1 | Exclusive read has modifiable bit set |
| err_rd_bytes_over | output | 1 | Exclusive read exceeds 128 bytes |
| err_rd_bytes_not_pow2 | output | 1 | Exclusive read byte count not a power of two |
| err_rd_len_over | output | 1 | Exclusive read longer than 16 beats |
| err_wr_modifiable | output | 1 | Exclusive write has modifiable bit set |
| err_wr_no_read | output | 1 | Exclusive write without a recorded read |
| err_wr_addr_mismatch | output | 1 | Write address differs from recorded read |
| err_wr_burst_mismatch | output | 1 | Write burst differs from recorded read |
| err_wr_cache_mismatch | output | 1 | Write cache differs from recorded read |

## Verification
Every error output comes from one register stage. A handshake seen at edge N therefore shows up on the outputs after edge N and stays there only until edge N+1. A new record is visible to a write handshaking at edge N+1 or later. The bench applies stimulus at the falling edge and advances its behavioural model at the rising edge. At the next falling edge it compares all nine outputs against the model, every cycle, so a pulse that is late, early or held too long is caught. Back-to-back and same-cycle read/write pairs pin down exactly when a record takes effect.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  localparam int unsigned EXCL_MAX_BYTES = 128;
  localparam int unsigned EXCL_MAX_BEATS = 16;
  localparam int unsigned BYTE_CNT_W     = 16;

  typedef struct packed {
    logic modifiable;
    logic bytes_over;
    logic not_pow2;
    logic len_over;
  } rd_err_t;

  typedef struct packed {
    logic modifiable;
    logic no_read;
    logic addr_mm;
    logic burst_mm;
    logic cache_mm;
  } wr_err_t;

  // total bytes of a burst: beats times bytes per beat
  function automatic logic [BYTE_CNT_W-1:0] excl_bytes(input logic [7:0] len,
                                                       input logic [2:0] size);
    logic [BYTE_CNT_W-1:0] beats;
    beats = BYTE_CNT_W'(len) + BYTE_CNT_W'(1);
    return beats << size;
  endfunction

  function automatic logic is_pow2(input logic [BYTE_CNT_W-1:0] v);
    return (v != '0) && ((v & (v - BYTE_CNT_W'(1))) == '0);
  endfunction

endpackage

// File: rtl/excl_rd_rules.sv
module excl_rd_rules
  import excl_mon_pkg::*;
#(
  parameter int unsigned MAX_BYTES = EXCL_MAX_BYTES,
  parameter int unsigned MAX_BEATS = EXCL_MAX_BEATS
) (
  input  logic [7:0] len,
  input  logic [2:0] size,
  input  logic [3:0] cache,
  output rd_err_t    err
);
  localparam logic [BYTE_CNT_W-1:0] BYTES_LIM = BYTE_CNT_W'(MAX_BYTES);
  localparam logic [8:0]            BEATS_LIM = 9'(MAX_BEATS);

  logic [BYTE_CNT_W-1:0] total_bytes;
  logic [8:0]            beats;

  always_comb begin
    total_bytes    = excl_bytes(len, size);
    beats          = {1'b0, len} + 9'd1;
    err.modifiable = cache[1];
    err.bytes_over = total_bytes > BYTES_LIM;
    err.not_pow2   = !is_pow2(total_bytes);
    err.len_over   = beats > BEATS_LIM;
  end
endmodule

// File: rtl/excl_record_table.sv
module excl_record_table #(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ID_W-1:0]   w_id,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [1:0]        w_burst,
  input  logic [3:0]        w_cache,
  input  logic [ID_W-1:0]   r_id,
  output logic              r_hit,
  output logic [ADDR_W-1:0] r_addr,
  output logic [1:0]        r_burst,
  output logic [3:0]        r_cache
);
  localparam int unsigned DEPTH = 1 << ID_W;

  logic              valid_q [DEPTH];
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [1:0]        burst_q [DEPTH];
  logic [3:0]        cache_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic sel;
    assign sel = we && (w_id == ID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_q[g] <= 1'b0;
      else if (sel) valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        addr_q[g]  <= w_addr;
        burst_q[g] <= w_burst;
        cache_q[g] <= w_cache;
      end
    end
  end

  assign r_hit   = valid_q[r_id];
  assign r_addr  = addr_q[r_id];
  assign r_burst = burst_q[r_id];
  assign r_cache = cache_q[r_id];

  AST_RECORD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> valid_q[$past(w_id)]) else $error("record not kept"); // R6
  AST_RECORD_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (we && r_id == w_id) |=> (!$stable(r_id) || (r_hit && r_addr == $past(w_addr))))
    else $error("record content lost"); // R11
endmodule

// File: rtl/excl_wr_match.sv
module excl_wr_match
  import excl_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              hit,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [1:0]        rec_burst,
  input  logic [3:0]        rec_cache,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        burst,
  input  logic [3:0]        cache,
  output wr_err_t           err
);
  always_comb begin
    err.modifiable = cache[1];
    err.no_read    = !hit;
    err.addr_mm    = hit && (addr  != rec_addr);
    err.burst_mm   = hit && (burst != rec_burst);
    err.cache_mm   = hit && (cache != rec_cache);
  end
endmodule

// File: rtl/excl_access_monitor.sv
module excl_access_monitor
  import excl_mon_pkg::*;
#(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [7:0]        ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  input  logic              ar_lock,
  input  logic [3:0]        ar_cache,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [1:0]        aw_burst,
  input  logic              aw_lock,
  input  logic [3:0]        aw_cache,
  output logic              err_rd_modifiable,
  output logic              err_rd_bytes_over,
  output logic              err_rd_bytes_not_pow2,
  output logic              err_rd_len_over,
  output logic              err_wr_modifiable,
  output logic              err_wr_no_read,
  output logic              err_wr_addr_mismatch,
  output logic              err_wr_burst_mismatch,
  output logic              err_wr_cache_mismatch
);
  // named handshake events
  logic ex_rd_fire, ex_wr_fire;
  assign ex_rd_fire = ar_valid && ar_ready && ar_lock;
  assign ex_wr_fire = aw_valid && aw_ready && aw_lock;

  rd_err_t rd_err_c, rd_err_q;
  wr_err_t wr_err_c, wr_err_q;

  logic              rec_hit;
  logic [ADDR_W-1:0] rec_addr;
  logic [1:0]        rec_burst;
  logic [3:0]        rec_cache;

  excl_rd_rules u_rd_rules (
    .len   (ar_len),
    .size  (ar_size),
    .cache (ar_cache),
    .err   (rd_err_c)
  );

  excl_record_table #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ex_rd_fire),
    .w_id    (ar_id),
    .w_addr  (ar_addr),
    .w_burst (ar_burst),
    .w_cache (ar_cache),
    .r_id    (aw_id),
    .r_hit   (rec_hit),
    .r_addr  (rec_addr),
    .r_burst (rec_burst),
    .r_cache (rec_cache)
  );

  excl_wr_match #(.ADDR_W(ADDR_W)) u_wr_match (
    .hit       (rec_hit),
    .rec_addr  (rec_addr),
    .rec_burst (rec_burst),
    .rec_cache (rec_cache),
    .addr      (aw_addr),
    .burst     (aw_burst),
    .cache     (aw_cache),
    .err       (wr_err_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_err_q <= '0;
      wr_err_q <= '0;
    end else begin
      rd_err_q <= ex_rd_fire ? rd_err_c : '0;
      wr_err_q <= ex_wr_fire ? wr_err_c : '0;
    end
  end

  assign err_rd_modifiable     = rd_err_q.modifiable;
  assign err_rd_bytes_over     = rd_err_q.bytes_over;
  assign err_rd_bytes_not_pow2 = rd_err_q.not_pow2;
  assign err_rd_len_over       = rd_err_q.len_over;
  assign err_wr_modifiable     = wr_err_q.modifiable;
  assign err_wr_no_read        = wr_err_q.no_read;
  assign err_wr_addr_mismatch  = wr_err_q.addr_mm;
  assign err_wr_burst_mismatch = wr_err_q.burst_mm;
  assign err_wr_cache_mismatch = wr_err_q.cache_mm;

  AST_RD_ERR_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd_modifiable || err_rd_bytes_over || err_rd_bytes_not_pow2 || err_rd_len_over)
      |-> $past(ar_valid && ar_ready && ar_lock)) else $error("stray read error"); // R13
  AST_WR_ERR_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_wr_modifiable || err_wr_no_read || err_wr_addr_mismatch ||
     err_wr_burst_mismatch || err_wr_cache_mismatch)
      |-> $past(aw_valid && aw_ready && aw_lock)) else $error("stray write error"); // R13
  AST_NO_READ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr_no_read |-> !(err_wr_addr_mismatch || err_wr_burst_mismatch || err_wr_cache_mismatch))
    else $error("match checked without record"); // R6
  AST_RD_MODIFIABLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_rd_modifiable |-> $past(ar_cache[1])) else $error("bad modifiable flag"); // R1
  AST_WR_MODIFIABLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr_modifiable |-> $past(aw_cache[1])) else $error("bad modifiable flag"); // R2
endmodule

// File: tb/excl_access_monitor_tb.sv
`timescale 1ns/1ps
module excl_access_monitor_tb;
  localparam int ID_W = 4;
  localparam int NID  = 1 << ID_W;

  typedef struct packed {
    logic        en;
    logic        rdy;
    logic [3:0]  id;
    logic [31:0] addr;
    logic [7:0]  len;
    logic [2:0]  size;
    logic [1:0]  burst;
    logic        lock;
    logic [3:0]  cache;
  } txn_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ar_valid = 0, ar_ready = 0, ar_lock = 0, aw_valid = 0, aw_ready = 0, aw_lock = 0;
  logic [3:0]  ar_id = 0, aw_id = 0, ar_cache = 0, aw_cache = 0;
  logic [31:0] ar_addr = 0, aw_addr = 0;
  logic [7:0]  ar_len = 0;
  logic [2:0]  ar_size = 0;
  logic [1:0]  ar_burst = 0, aw_burst = 0;
  logic e_rmod, e_rover, e_rpow, e_rlen, e_wmod, e_wnr, e_wadr, e_wbur, e_wcac;

  int tests = 0, fails = 0;
  bit done = 0;

  // model state
  bit          m_vld  [NID];
  logic [31:0] m_addr [NID];
  logic [1:0]  m_burst[NID];
  logic [3:0]  m_cache[NID];
  logic [8:0]  exp_v;

  always #2.5 clk = ~clk;

  excl_access_monitor #(.ID_W(ID_W), .ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst), .ar_lock(ar_lock),
    .ar_cache(ar_cache),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
    .aw_burst(aw_burst), .aw_lock(aw_lock), .aw_cache(aw_cache),
    .err_rd_modifiable(e_rmod), .err_rd_bytes_over(e_rover),
    .err_rd_bytes_not_pow2(e_rpow), .err_rd_len_over(e_rlen),
    .err_wr_modifiable(e_wmod), .err_wr_no_read(e_wnr),
    .err_wr_addr_mismatch(e_wadr), .err_wr_burst_mismatch(e_wbur),
    .err_wr_cache_mismatch(e_wcac)
  );

  function automatic txn_t mk(bit en, bit rdy, int id, logic [31:0] addr, int len,
                              int size, int burst, bit lock, int cache);
    txn_t t;
    t.en = en; t.rdy = rdy; t.id = 4'(id); t.addr = addr; t.len = 8'(len);
    t.size = 3'(size); t.burst = 2'(burst); t.lock = lock; t.cache = 4'(cache);
    return t;
  endfunction

  function automatic txn_t idle();
    return mk(0, 0, 0, 32'h0, 0, 0, 0, 0, 0);
  endfunction

  task automatic check(string req, string nm, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, nm, got, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    check({"R1 ", tag}, "rd_modifiable", e_rmod, exp_v[8]);
    check({"R3 ", tag}, "rd_bytes_over", e_rover, exp_v[7]);
    check({"R4 ", tag}, "rd_not_pow2",   e_rpow, exp_v[6]);
    check({"R5 ", tag}, "rd_len_over",   e_rlen, exp_v[5]);
    check({"R2 ", tag}, "wr_modifiable", e_wmod, exp_v[4]);
    check({"R6 ", tag}, "wr_no_read",    e_wnr,  exp_v[3]);
    check({"R7 ", tag}, "wr_addr_mm",    e_wadr, exp_v[2]);
    check({"R8 ", tag}, "wr_burst_mm",   e_wbur, exp_v[1]);
    check({"R9 ", tag}, "wr_cache_mm",   e_wcac, exp_v[0]);
  endtask

  // one cycle: drive at falling edge, model steps at rising edge, compare at next falling edge
  task automatic step(txn_t r, txn_t w, string tag);
    bit rfire, wfire;
    int beats, bytes;
    ar_valid = r.en; ar_ready = r.rdy; ar_id = r.id; ar_addr = r.addr; ar_len = r.len;
    ar_size = r.size; ar_burst = r.burst; ar_lock = r.lock; ar_cache = r.cache;
    aw_valid = w.en; aw_ready = w.rdy; aw_id = w.id; aw_addr = w.addr;
    aw_burst = w.burst; aw_lock = w.lock; aw_cache = w.cache;
    rfire = r.en && r.rdy && r.lock;
    wfire = w.en && w.rdy && w.lock;
    exp_v = '0;
    if (rfire) begin
      beats = int'(r.len) + 1;
      bytes = beats * (1 << r.size);
      exp_v[8] = r.cache[1];
      exp_v[7] = bytes > 128;
      exp_v[6] = $countones(bytes) != 1;
      exp_v[5] = beats > 16;
    end
    if (wfire) begin
      exp_v[4] = w.cache[1];
      if (!m_vld[w.id]) exp_v[3] = 1'b1;
      else begin
        exp_v[2] = w.addr  != m_addr[w.id];
        exp_v[1] = w.burst != m_burst[w.id];
        exp_v[0] = w.cache != m_cache[w.id];
      end
    end
    @(posedge clk);
    if (rfire) begin   // R11: update only after the write saw the old record
      m_vld[r.id] = 1; m_addr[r.id] = r.addr; m_burst[r.id] = r.burst; m_cache[r.id] = r.cache;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset(string tag);
    ar_valid = 0; aw_valid = 0; ar_ready = 0; aw_ready = 0; ar_lock = 0; aw_lock = 0;
    rst_n = 1'b0;
    for (int i = 0; i < NID; i++) m_vld[i] = 0;
    exp_v = '0;
    #1;
    compare_all({"R12 ", tag});
    repeat (2) @(negedge clk);
    compare_all({"R12 ", tag});
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NID; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    do_reset("initial");
    @(negedge clk);

    // R6: write before any read -> no record
    step(idle(), mk(1,1,2,32'h100,0,0,1,1,0), "write without read");
    // legal read, then matching write -> clean
    step(mk(1,1,2,32'h100,3,2,1,1,0), idle(), "legal read 16B");
    step(idle(), mk(1,1,2,32'h100,0,0,1,1,0), "matching write");
    // R13: idle cycle shows pulse gone
    step(idle(), idle(), "pulse width");
    // R7 R8 R9 mismatches individually and together
    step(idle(), mk(1,1,2,32'h104,0,0,1,1,0), "R7 addr mismatch");
    step(idle(), mk(1,1,2,32'h100,0,0,2,1,0), "R8 burst mismatch");
    step(idle(), mk(1,1,2,32'h100,0,0,1,1,1), "R9 cache mismatch");
    step(idle(), mk(1,1,2,32'h200,0,0,0,1,3), "R2 R7 R8 R9 combined");
    // R1 read modifiable
    step(mk(1,1,5,32'h40,0,3,1,1,2), idle(), "R1 modifiable read");
    step(idle(), mk(1,1,5,32'h40,0,0,1,1,2), "R2 write cache bit1 match");
    // R3 R4 R5 boundaries
    step(mk(1,1,1,32'h0,0,7,1,1,0), idle(), "R3 128B single beat ok");
    step(mk(1,1,1,32'h0,15,3,1,1,0), idle(), "R3 R5 16x8=128 ok");
    step(mk(1,1,1,32'h0,15,4,1,1,0), idle(), "R3 256B over");
    step(mk(1,1,1,32'h0,16,0,1,1,0), idle(), "R5 17 beats");
    step(mk(1,1,1,32'h0,2,0,1,1,0), idle(), "R4 3 bytes");
    step(mk(1,1,1,32'h0,255,7,1,1,2), idle(), "R1 R3 R5 max burst");
    // R10: non-exclusive and stalled handshakes ignored
    step(mk(1,1,7,32'h80,40,7,1,0,2), mk(1,1,7,32'h80,0,0,1,0,2), "R10 non-exclusive");
    step(mk(1,0,7,32'h80,0,0,1,1,0), mk(1,0,7,32'h80,0,0,1,1,2), "R10 no ready");
    step(idle(), mk(1,1,7,32'h80,0,0,1,1,0), "R10 no record created");
    step(mk(1,1,2,32'h999,0,0,3,0,5), idle(), "R10 non-excl read keeps record");
    step(idle(), mk(1,1,2,32'h100,0,0,1,1,0), "R10 R11 id2 record unchanged");
    // R11 record persists after writes, replaced by next read
    step(idle(), mk(1,1,2,32'h100,0,0,1,1,0), "R11 retried write");
    step(mk(1,1,2,32'h300,0,2,2,1,4), mk(1,1,2,32'h100,0,0,1,1,0), "R11 same cycle old record");
    step(idle(), mk(1,1,2,32'h300,0,0,2,1,4), "R11 new record");
    // back to back reads then write
    step(mk(1,1,3,32'h10,1,1,1,1,0), idle(), "b2b read 1");
    step(mk(1,1,3,32'h20,1,1,1,1,0), mk(1,1,3,32'h10,0,0,1,1,0), "b2b write sees first");
    step(idle(), mk(1,1,3,32'h20,0,0,1,1,0), "b2b write sees second");
    // R12 reset mid-run clears records
    do_reset("mid-run");
    @(negedge clk);
    step(idle(), mk(1,1,3,32'h20,0,0,1,1,0), "R12 record cleared");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      automatic int lens[7] = '{0, 1, 3, 7, 15, 16, 2};
      automatic txn_t r = mk($urandom_range(0,3) != 0, $urandom_range(0,3) != 0,
                             $urandom_range(0,3), 32'($urandom_range(0,3) * 16),
                             lens[$urandom_range(0,6)], $urandom_range(0,7),
                             $urandom_range(0,2), $urandom_range(0,3) != 0,
                             $urandom_range(0,3));
      automatic txn_t w = mk($urandom_range(0,3) != 0, $urandom_range(0,3) != 0,
                             $urandom_range(0,3), 32'($urandom_range(0,3) * 16), 0, 0,
                             $urandom_range(0,2), $urandom_range(0,3) != 0,
                             $urandom_range(0,3));
      step(r, w, "random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule